// File: doc/BRIEF.md
# SD Host Control and Status Register File

This block is the software-visible register file of a small SD/MMC host controller. A processor reaches it over a 32-bit bus addressed by word index, with one select strobe and one write flag per cycle. It holds the command word, the argument, the captured response, the data-transfer setup (block-size exponent, direction, DMA enable, data enable, threshold, length, timer), the interrupt mask, power, clock and bus-width settings. It drives all of these settings out to the card-side engines as plain configuration signals.

The card-side engines report what happened through one-cycle event inputs. The block turns those events into sticky status bits. Software clears the status bits through a separate write-one-to-clear register. A single level interrupt is raised while any unmasked status bit is set. Card presence and write protection are shown as live levels next to the sticky bits. A change in card presence is itself latched as a sticky event. Setting the reset bit of the command word starts a controller soft reset. The bit reads back as 1 while the reset runs and clears itself after a fixed number of cycles, so software can poll it.

Top module: `sd_csr_top`

## Requirements
- R1: Word indices map as follows: 0 command, 1 argument, 2..5 response, 6 response command, 7 data control, 8 data timer, 9 data length, 10 status, 11 clear, 12 interrupt mask, 13 power, 14 clock, 15 bus width, 16 data window, 17 feature, 18 revision. A write takes effect at the clock edge where it is sampled. busRdata is combinational from the registers when busSel=1 and busWr=0, and is 0 otherwise. Argument and timer keep 32 bits, power keeps bits 4:0 and clock keeps bits 9:0. Bits outside the stored fields read 0. The data window, the clear register and unused indices read 0. Index 18 reads the REVISION parameter.
- R2: Event input bit i (i=0..9) sets status bit i at the next edge, and the bit stays set until it is cleared. The positions are: 0 response CRC fail, 1 data CRC fail, 2 response timeout, 3 data timeout, 4 response CRC ok, 5 data CRC ok, 6 command sent, 7 data end, 8 FIFO underrun, 9 FIFO overrun.
- R3: Writing index 11 clears each status bit 10:0 whose write-data bit is 1 and leaves the other bits alone. If an event and a clear hit the same bit in the same cycle, the bit stays set. Index 11 always reads 0.
- R4: irq is the OR over bits 10:0 of status AND mask. It changes in the same cycle as the status or mask register that causes it. The mask register (index 12) stores bits 10:0.
- R5: Status bit 11 is the live cardAbsent level (1 = no card). Status bit 12 is the live writeProt level. Status bit 10 is set at the edge where cardAbsent differs from the level sampled at the previous edge. The sampled level starts as absent after reset.
- R6: A command write with bit 10 set clears command bits 9:0 and starts the soft reset. Command bit 10 and softRst then read 1 for exactly RST_CYCLES cycles and return to 0 by themselves. While softRst is 1, status bits 10:0 are held at 0 and events are ignored.
- R7: A command write with bit 9 = 1 and bit 10 = 0 stores bits 9:0 (index 5:0, need-response 6, long-response 7, application 8, enable 9) and pulses cmdGo for the following cycle.
- R8: A data-control write stores bits 7:0 (block-size exponent 3:0, write 4, DMA 5, data enable 6, threshold 7). If bit 8 is set, it pulses fifoFlush for the following cycle. Bit 8 always reads 0.
- R9: rspWe loads response words 2..5 from rspData bits 31:0, 63:32, 95:64 and 127:96, and loads index 6 from the 7-bit rspCmd. Bus writes to indices 2..6 have no effect.
- R10: The data length keeps 24 bits and its upper byte reads 0. The bus-width register stores bits 2:0 and reads the BUS_CAP parameter in bits 4:3 (1 = 4-bit, 2 = 8-bit). Index 17 reads FIFO_WORDS.
- R11: After reset every stored register, every status bit 10:0, irq and every pulse output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| evtIn | input | 10 | One-cycle event pulses from the card-side engines |
| cardAbsent | input | 1 | Level, 1 when no card is inserted |
| writeProt | input | 1 | Level, write-protect switch |
| rspWe | input | 1 | Load strobe for the response |
| rspData | input | 128 | Response payload |
| rspCmd | input | 7 | Index and application flag of the responding command |
| irq | output | 1 | Level interrupt |
| cmdGo | output | 1 | One-cycle command start pulse |
| fifoFlush | output | 1 | One-cycle FIFO reset pulse |
| softRst | output | 1 | Controller soft reset in progress |
| cfgCmd | output | 10 | Stored command fields |
| cfgArg | output | 32 | Command argument |
| cfgDataCtrl | output | 8 | Stored data-control fields |
| cfgDataTimer | output | 32 | Data timeout value |
| cfgDataLen | output | 24 | Transfer length in bytes |
| cfgPower | output | 5 | Power enable and level |
| cfgClock | output | 10 | Clock control |
| cfgBusWidth | output | 3 | Selected bus width |

## Verification
Stored registers, sticky bits, the sampled card level and the two pulses are all due one edge after the cycle whose inputs cause them. Read data, irq and the two live status bits follow those registers and the current inputs with no extra delay. The soft reset holds the status at zero starting one edge after the reset write, and it lasts RST_CYCLES cycles. The reference model in the bench advances at every rising edge from the inputs sampled there. The bench changes inputs just after that edge and compares every output at the falling edge, so each result is checked in the cycle it becomes due and not before.

// File: rtl/sdcsr_pkg.sv
package sdcsr_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 32;
  localparam int NUM_HW_EVT = 10;
  localparam int NUM_EVT    = NUM_HW_EVT + 1;
  localparam int RSP_WORDS  = 4;
  localparam int RSP_BITS   = RSP_WORDS * DATA_W;
  localparam int LEN_W      = 24;
  localparam int CMD_W      = 10;
  localparam int DCTL_W     = 8;
  localparam int POW_W      = 5;
  localparam int CLK_W      = 10;
  localparam int BW_W       = 3;
  localparam int RSPCMD_W   = 7;
  localparam int BIT_RST    = 10;
  localparam int BIT_GO     = 9;
  localparam int BIT_FLUSH  = 8;

  localparam logic [ADDR_W-1:0] IDX_CMD    = 5'd0;
  localparam logic [ADDR_W-1:0] IDX_ARG    = 5'd1;
  localparam logic [ADDR_W-1:0] IDX_RSP0   = 5'd2;
  localparam logic [ADDR_W-1:0] IDX_RSP1   = 5'd3;
  localparam logic [ADDR_W-1:0] IDX_RSP2   = 5'd4;
  localparam logic [ADDR_W-1:0] IDX_RSP3   = 5'd5;
  localparam logic [ADDR_W-1:0] IDX_RSPCMD = 5'd6;
  localparam logic [ADDR_W-1:0] IDX_DCTL   = 5'd7;
  localparam logic [ADDR_W-1:0] IDX_TIMER  = 5'd8;
  localparam logic [ADDR_W-1:0] IDX_LEN    = 5'd9;
  localparam logic [ADDR_W-1:0] IDX_STAT   = 5'd10;
  localparam logic [ADDR_W-1:0] IDX_CLR    = 5'd11;
  localparam logic [ADDR_W-1:0] IDX_MASK   = 5'd12;
  localparam logic [ADDR_W-1:0] IDX_POW    = 5'd13;
  localparam logic [ADDR_W-1:0] IDX_CLK    = 5'd14;
  localparam logic [ADDR_W-1:0] IDX_BW     = 5'd15;
  localparam logic [ADDR_W-1:0] IDX_WIN    = 5'd16;
  localparam logic [ADDR_W-1:0] IDX_FEAT   = 5'd17;
  localparam logic [ADDR_W-1:0] IDX_REV    = 5'd18;

  typedef struct packed {
    logic wrCmd;
    logic wrArg;
    logic wrDctl;
    logic wrTimer;
    logic wrLen;
    logic wrClr;
    logic wrMask;
    logic wrPower;
    logic wrClock;
    logic wrBw;
    logic rdEn;
    logic rstStart;
    logic softRst;
  } csrStrb_t;
endpackage

// File: rtl/sd_csr_ctrl.sv
module sd_csr_ctrl
  import sdcsr_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdataRst,
  output csrStrb_t          strb
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic             wrEn;
  logic             rstBit;
  logic [CNT_W-1:0] rstCnt;

  assign wrEn = busSel & busWr;

  always_comb begin
    strb          = '0;
    strb.rdEn     = busSel & ~busWr;
    strb.wrCmd    = wrEn && (busAddr == IDX_CMD);
    strb.wrArg    = wrEn && (busAddr == IDX_ARG);
    strb.wrDctl   = wrEn && (busAddr == IDX_DCTL);
    strb.wrTimer  = wrEn && (busAddr == IDX_TIMER);
    strb.wrLen    = wrEn && (busAddr == IDX_LEN);
    strb.wrClr    = wrEn && (busAddr == IDX_CLR);
    strb.wrMask   = wrEn && (busAddr == IDX_MASK);
    strb.wrPower  = wrEn && (busAddr == IDX_POW);
    strb.wrClock  = wrEn && (busAddr == IDX_CLK);
    strb.wrBw     = wrEn && (busAddr == IDX_BW);
    strb.rstStart = strb.wrCmd & wdataRst;
    strb.softRst  = rstBit;
  end

  // Soft reset sequencer: the bit stays high for RST_CYCLES cycles.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBit <= 1'b0;
      rstCnt <= '0;
    end else if (strb.rstStart) begin
      rstBit <= 1'b1;
      rstCnt <= CNT_W'(RST_CYCLES - 1);
    end else if (rstBit) begin
      if (rstCnt == '0) rstBit <= 1'b0;
      else              rstCnt <= rstCnt - 1'b1;
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCmd, strb.wrArg, strb.wrDctl, strb.wrTimer, strb.wrLen,
              strb.wrClr, strb.wrMask, strb.wrPower, strb.wrClock, strb.wrBw})); // R1
  AST_RST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstBit) |-> $past(strb.rstStart)); // R6
  AST_RST_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstBit) |-> ($past(rstCnt) == '0)); // R6
endmodule

// File: rtl/sd_csr_dp.sv
module sd_csr_dp
  import sdcsr_pkg::*;
#(
  parameter int          FIFO_WORDS = 16,
  parameter logic [31:0] REVISION   = 32'h0000_0103,
  parameter logic [1:0]  BUS_CAP    = 2'd2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csrStrb_t              strb,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_HW_EVT-1:0] evtIn,
  input  logic                  cardAbsent,
  input  logic                  writeProt,
  input  logic                  rspWe,
  input  logic [RSP_BITS-1:0]   rspData,
  input  logic [RSPCMD_W-1:0]   rspCmd,
  output logic                  irq,
  output logic                  cmdGo,
  output logic                  fifoFlush,
  output logic [CMD_W-1:0]      cfgCmd,
  output logic [DATA_W-1:0]     cfgArg,
  output logic [DCTL_W-1:0]     cfgDataCtrl,
  output logic [DATA_W-1:0]     cfgDataTimer,
  output logic [LEN_W-1:0]      cfgDataLen,
  output logic [POW_W-1:0]      cfgPower,
  output logic [CLK_W-1:0]      cfgClock,
  output logic [BW_W-1:0]       cfgBusWidth
);
  logic [RSP_WORDS-1:0][DATA_W-1:0] rspQ;
  logic [RSPCMD_W-1:0] rspCmdQ;
  logic [NUM_EVT-1:0]  sticky, maskQ, evtVec, clrVec;
  logic                cdPrev, cardChg;
  logic [DATA_W-1:0]   statusWord;

  // Event merge: card presence toggle joins the engine events on top.
  assign cardChg    = cardAbsent ^ cdPrev;
  assign evtVec     = {cardChg, evtIn};
  assign clrVec     = strb.wrClr ? busWdata[NUM_EVT-1:0] : '0;
  assign statusWord = {{(DATA_W-NUM_EVT-2){1'b0}}, writeProt, cardAbsent, sticky};
  assign irq        = |(sticky & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sticky <= '0;
      cdPrev <= 1'b1;
    end else begin
      cdPrev <= cardAbsent;
      if (strb.softRst) sticky <= '0;
      else              sticky <= (sticky & ~clrVec) | evtVec;
    end
  end

  // Software-written configuration.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCmd       <= '0;
      cfgArg       <= '0;
      cfgDataCtrl  <= '0;
      cfgDataTimer <= '0;
      cfgDataLen   <= '0;
      cfgPower     <= '0;
      cfgClock     <= '0;
      cfgBusWidth  <= '0;
      maskQ        <= '0;
      cmdGo        <= 1'b0;
      fifoFlush    <= 1'b0;
    end else begin
      cmdGo     <= strb.wrCmd & busWdata[BIT_GO] & ~busWdata[BIT_RST];
      fifoFlush <= strb.wrDctl & busWdata[BIT_FLUSH];
      if (strb.wrCmd)   cfgCmd       <= busWdata[BIT_RST] ? '0 : busWdata[CMD_W-1:0];
      if (strb.wrArg)   cfgArg       <= busWdata;
      if (strb.wrDctl)  cfgDataCtrl  <= busWdata[DCTL_W-1:0];
      if (strb.wrTimer) cfgDataTimer <= busWdata;
      if (strb.wrLen)   cfgDataLen   <= busWdata[LEN_W-1:0];
      if (strb.wrPower) cfgPower     <= busWdata[POW_W-1:0];
      if (strb.wrClock) cfgClock     <= busWdata[CLK_W-1:0];
      if (strb.wrBw)    cfgBusWidth  <= busWdata[BW_W-1:0];
      if (strb.wrMask)  maskQ        <= busWdata[NUM_EVT-1:0];
    end
  end

  // Response capture from the command engine.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspQ    <= '0;
      rspCmdQ <= '0;
    end else if (rspWe) begin
      for (int w = 0; w < RSP_WORDS; w++) rspQ[w] <= rspData[w*DATA_W +: DATA_W];
      rspCmdQ <= rspCmd;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      case (busAddr)
        IDX_CMD:    busRdata = DATA_W'({strb.softRst, cfgCmd});
        IDX_ARG:    busRdata = cfgArg;
        IDX_RSP0:   busRdata = rspQ[0];
        IDX_RSP1:   busRdata = rspQ[1];
        IDX_RSP2:   busRdata = rspQ[2];
        IDX_RSP3:   busRdata = rspQ[3];
        IDX_RSPCMD: busRdata = DATA_W'(rspCmdQ);
        IDX_DCTL:   busRdata = DATA_W'(cfgDataCtrl);
        IDX_TIMER:  busRdata = cfgDataTimer;
        IDX_LEN:    busRdata = DATA_W'(cfgDataLen);
        IDX_STAT:   busRdata = statusWord;
        IDX_MASK:   busRdata = DATA_W'(maskQ);
        IDX_POW:    busRdata = DATA_W'(cfgPower);
        IDX_CLK:    busRdata = DATA_W'(cfgClock);
        IDX_BW:     busRdata = DATA_W'({BUS_CAP, cfgBusWidth});
        IDX_FEAT:   busRdata = DATA_W'(FIFO_WORDS);
        IDX_REV:    busRdata = REVISION;
        default:    busRdata = '0;
      endcase
    end
  end

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtVec) && !strb.softRst) |=> ((sticky & $past(evtVec)) == $past(evtVec))); // R2
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((sticky & $past(busWdata[NUM_EVT-1:0] & ~evtVec)) == '0)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq); // R4
  AST_SOFT_RST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.softRst && $past(strb.softRst)) |-> (sticky == '0)); // R6
  AST_GO_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmdGo |-> $past(strb.wrCmd)); // R7
  AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> $past(strb.wrDctl)); // R8
endmodule

// File: rtl/sd_csr_top.sv
module sd_csr_top
  import sdcsr_pkg::*;
#(
  parameter int          RST_CYCLES = 8,
  parameter int          FIFO_WORDS = 16,
  parameter logic [31:0] REVISION   = 32'h0000_0103,
  parameter logic [1:0]  BUS_CAP    = 2'd2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_HW_EVT-1:0] evtIn,
  input  logic                  cardAbsent,
  input  logic                  writeProt,
  input  logic                  rspWe,
  input  logic [RSP_BITS-1:0]   rspData,
  input  logic [RSPCMD_W-1:0]   rspCmd,
  output logic                  irq,
  output logic                  cmdGo,
  output logic                  fifoFlush,
  output logic                  softRst,
  output logic [CMD_W-1:0]      cfgCmd,
  output logic [DATA_W-1:0]     cfgArg,
  output logic [DCTL_W-1:0]     cfgDataCtrl,
  output logic [DATA_W-1:0]     cfgDataTimer,
  output logic [LEN_W-1:0]      cfgDataLen,
  output logic [POW_W-1:0]      cfgPower,
  output logic [CLK_W-1:0]      cfgClock,
  output logic [BW_W-1:0]       cfgBusWidth
);
  csrStrb_t strb;

  sd_csr_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .wdataRst(busWdata[BIT_RST]), .strb(strb)
  );

  sd_csr_dp #(.FIFO_WORDS(FIFO_WORDS), .REVISION(REVISION), .BUS_CAP(BUS_CAP)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn),
    .cardAbsent(cardAbsent), .writeProt(writeProt), .rspWe(rspWe),
    .rspData(rspData), .rspCmd(rspCmd), .irq(irq), .cmdGo(cmdGo),
    .fifoFlush(fifoFlush), .cfgCmd(cfgCmd), .cfgArg(cfgArg),
    .cfgDataCtrl(cfgDataCtrl), .cfgDataTimer(cfgDataTimer),
    .cfgDataLen(cfgDataLen), .cfgPower(cfgPower), .cfgClock(cfgClock),
    .cfgBusWidth(cfgBusWidth)
  );

  assign softRst = strb.softRst;
endmodule

// File: tb/sd_csr_top_tb_top.sv
`timescale 1ns/1ps
module sd_csr_top_tb_top;
  localparam int RSTC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [9:0] evtIn = '0;
  logic cardAbsent = 1'b1, writeProt = 1'b0, rspWe = 1'b0;
  logic [127:0] rspData = '0;
  logic [6:0] rspCmd = '0;
  logic irq, cmdGo, fifoFlush, softRst;
  logic [9:0] cfgCmd;
  logic [31:0] cfgArg, cfgDataTimer;
  logic [7:0] cfgDataCtrl;
  logic [23:0] cfgDataLen;
  logic [4:0] cfgPower;
  logic [9:0] cfgClock;
  logic [2:0] cfgBusWidth;

  int checks = 0, fails = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  sd_csr_top #(.RST_CYCLES(RSTC), .FIFO_WORDS(16), .REVISION(32'h0000_0103), .BUS_CAP(2'd2)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .cardAbsent(cardAbsent),
    .writeProt(writeProt), .rspWe(rspWe), .rspData(rspData), .rspCmd(rspCmd),
    .irq(irq), .cmdGo(cmdGo), .fifoFlush(fifoFlush), .softRst(softRst),
    .cfgCmd(cfgCmd), .cfgArg(cfgArg), .cfgDataCtrl(cfgDataCtrl),
    .cfgDataTimer(cfgDataTimer), .cfgDataLen(cfgDataLen), .cfgPower(cfgPower),
    .cfgClock(cfgClock), .cfgBusWidth(cfgBusWidth)
  );

  // Behavioural reference model
  logic [31:0] mReg [0:31];
  logic [10:0] mSticky;
  logic        mCdPrev, mGo, mFlush;
  int          mRstLeft;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mReg[i] = 32'h0;
      mSticky = '0; mCdPrev = 1'b1; mGo = 1'b0; mFlush = 1'b0; mRstLeft = 0;
    end else begin
      logic [10:0] ev, clr;
      bit wr, wasRst;
      wr = busSel && busWr;
      wasRst = (mRstLeft > 0);
      ev = {cardAbsent != mCdPrev, evtIn};
      clr = (wr && busAddr == 5'd11) ? busWdata[10:0] : 11'h0;
      mSticky = wasRst ? 11'h0 : ((mSticky & ~clr) | ev);
      mCdPrev = cardAbsent;
      mGo = wr && busAddr == 5'd0 && busWdata[9] && !busWdata[10];
      mFlush = wr && busAddr == 5'd7 && busWdata[8];
      if (wr && busAddr == 5'd0 && busWdata[10]) mRstLeft = RSTC;
      else if (mRstLeft > 0) mRstLeft--;
      if (wr) begin
        case (busAddr)
          5'd0:  mReg[0]  = busWdata[10] ? 32'h0 : {22'h0, busWdata[9:0]};
          5'd1:  mReg[1]  = busWdata;
          5'd7:  mReg[7]  = {24'h0, busWdata[7:0]};
          5'd8:  mReg[8]  = busWdata;
          5'd9:  mReg[9]  = {8'h0, busWdata[23:0]};
          5'd12: mReg[12] = {21'h0, busWdata[10:0]};
          5'd13: mReg[13] = {27'h0, busWdata[4:0]};
          5'd14: mReg[14] = {22'h0, busWdata[9:0]};
          5'd15: mReg[15] = {29'h0, busWdata[2:0]};
          default: ;
        endcase
      end
      if (rspWe) begin
        for (int w = 0; w < 4; w++) mReg[2+w] = rspData[w*32 +: 32];
        mReg[6] = {25'h0, rspCmd};
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (!(busSel && !busWr)) return 32'h0;
    case (a)
      5'd0: return mReg[0] | ((mRstLeft > 0) ? 32'h400 : 32'h0);
      5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd12, 5'd13, 5'd14: return mReg[a];
      5'd10: return {19'h0, writeProt, cardAbsent, mSticky};
      5'd15: return mReg[15] | 32'h10;
      5'd17: return 32'd16;
      5'd18: return 32'h103;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [4:0] a);
    case (a)
      5'd0: return "R7";
      5'd2, 5'd3, 5'd4, 5'd5, 5'd6: return "R9";
      5'd7: return "R8";
      5'd9, 5'd15, 5'd17: return "R10";
      5'd10: return "R2";
      5'd11: return "R3";
      5'd12: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (running) begin
      cmp(tagOf(busAddr), busRdata, expRead(busAddr));
      cmp("R4", 32'(irq), 32'(|(mSticky & mReg[12][10:0])));
      cmp("R7", 32'(cmdGo), 32'(mGo));
      cmp("R8", 32'(fifoFlush), 32'(mFlush));
      cmp("R6", 32'(softRst), 32'(mRstLeft > 0));
      cmp("R7", 32'(cfgCmd), mReg[0]);
      cmp("R1", cfgArg, mReg[1]);
      cmp("R10", 32'(cfgDataLen), mReg[9]);
      cmp("R1", {cfgPower, cfgClock, cfgBusWidth, cfgDataCtrl}, {mReg[13][4:0], mReg[14][9:0], mReg[15][2:0], mReg[7][7:0]});
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    tick(1);
    busSel = 0; busWr = 0;
  endtask
  task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    cmp(tag, busRdata, e);
    tick(1);
    busSel = 0;
  endtask
  task automatic chkBit(input logic v, input logic e, input string tag);
    @(negedge clk);
    cmp(tag, 32'(v), 32'(e));
    tick(1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rstN = 1;
    running = 1;
    // R11 reset state
    chk(5'd10, 32'h800, "R11");
    chk(5'd0, 32'h0, "R11");
    chk(5'd12, 32'h0, "R11");
    chkBit(irq, 1'b0, "R11");
    // R1 / R10 constants and masking
    chk(5'd17, 32'd16, "R10");
    chk(5'd18, 32'h103, "R1");
    chk(5'd15, 32'h10, "R10");
    wr(5'd1, 32'hDEAD_BEEF); chk(5'd1, 32'hDEAD_BEEF, "R1");
    wr(5'd9, 32'hFFFF_FFFF); chk(5'd9, 32'h00FF_FFFF, "R10");
    wr(5'd15, 32'hFF);       chk(5'd15, 32'h17, "R10");
    wr(5'd13, 32'hFF);       chk(5'd13, 32'h1F, "R1");
    wr(5'd14, 32'hFFFF);     chk(5'd14, 32'h3FF, "R1");
    wr(5'd8, 32'h1234_5678); chk(5'd8, 32'h1234_5678, "R1");
    wr(5'd16, 32'hFFFF_FFFF); chk(5'd16, 32'h0, "R1");
    chk(5'd25, 32'h0, "R1");
    wr(5'd11, 32'h7FF);      chk(5'd11, 32'h0, "R3");
    // R2 sticky events
    evtIn = 10'h0A5; tick(1); evtIn = '0;
    chk(5'd10, 32'h8A5, "R2");
    tick(3);
    chk(5'd10, 32'h8A5, "R2");
    // R4 interrupt masking
    chkBit(irq, 1'b0, "R4");
    wr(5'd12, 32'h004); chkBit(irq, 1'b1, "R4");
    wr(5'd12, 32'h002); chkBit(irq, 1'b0, "R4");
    // R3 clear, and event beats clear in the same cycle
    wr(5'd11, 32'h001); chk(5'd10, 32'h8A4, "R3");
    evtIn = 10'h020; wr(5'd11, 32'h020); evtIn = '0;
    chk(5'd10, 32'h8A4, "R3");
    wr(5'd11, 32'h7FF); chk(5'd10, 32'h800, "R3");
    // R5 card presence and write protect
    cardAbsent = 0; tick(1);
    chk(5'd10, 32'h400, "R5");
    writeProt = 1;
    chk(5'd10, 32'h1400, "R5");
    wr(5'd12, 32'h400); chkBit(irq, 1'b1, "R5");
    wr(5'd11, 32'h400); chk(5'd10, 32'h1000, "R5");
    // R9 response capture; bus writes ignored
    rspData = 128'h4444_4444_3333_3333_2222_2222_1111_1111; rspCmd = 7'h55; rspWe = 1;
    tick(1); rspWe = 0;
    wr(5'd3, 32'h0);
    chk(5'd2, 32'h1111_1111, "R9");
    chk(5'd3, 32'h2222_2222, "R9");
    chk(5'd5, 32'h4444_4444, "R9");
    chk(5'd6, 32'h55, "R9");
    // R8 data control with FIFO flush
    wr(5'd7, 32'h1FF); chkBit(fifoFlush, 1'b1, "R8");
    chkBit(fifoFlush, 1'b0, "R8");
    chk(5'd7, 32'hFF, "R8");
    // R7 command start
    wr(5'd0, 32'h2D1); chkBit(cmdGo, 1'b1, "R7");
    chk(5'd0, 32'h2D1, "R7");
    wr(5'd0, 32'h0D1); chkBit(cmdGo, 1'b0, "R7");
    // R6 soft reset
    evtIn = 10'h3FF; tick(1); evtIn = '0;
    wr(5'd0, 32'h600);
    chkBit(cmdGo, 1'b0, "R6");
    chk(5'd10, 32'h1000, "R6");
    evtIn = 10'h3FF; tick(1); evtIn = '0;
    chk(5'd0, 32'h400, "R6");
    chk(5'd10, 32'h1000, "R6");
    tick(RSTC);
    chk(5'd0, 32'h0, "R6");
    evtIn = 10'h001; tick(1); evtIn = '0;
    chk(5'd10, 32'h1001, "R6");
    tick(2);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule